// File: doc/BRIEF.md
# Programmable High/Low-Time Clock Divider

This block produces one divided clock from a fast source clock that arrives as eight copies, each shifted by one eighth of a period. A three-bit field picks which copy drives the counters. The output then rises after a programmable number of start-up cycles and goes high and low for separately programmed numbers of source cycles. This one mechanism sets both the divide ratio and the duty cycle, and it places the output at a coarse phase offset.

An edge option holds the high phase on until the following falling source edge. This moves half a source cycle from the low phase to the high phase, so odd ratios can run at an even duty cycle. A bypass option sends the selected source copy straight to the output, which gives divide-by-one.

All settings come from two 16-bit words. The block loads them only while its reset input is high. After reset is released the settings stay frozen until the next reset.

Top module: `hl_clk_divider`

## Requirements
- R1: While `rst` is high, `clk_out` is low. Words on `cfg_a`/`cfg_b` are captured on rising edges of `phase_clk[0]` only while `rst` is high. Changes to the words after release have no effect on the output.
- R2: With bypass and edge clear, the output stays high for H cycles of the selected source and low for L cycles, so its period is H+L cycles. H is `cfg_a[11:6]` and L is `cfg_a[5:0]`.
- R3: A value of 0 in the H or L field means 64 cycles.
- R4: When the edge bit `cfg_b[7]` is set, the high time is H+0.5 cycles and the low time is L-0.5 cycles. The period does not change.
- R5: When the bypass bit `cfg_b[6]` is set, the output follows the selected source copy: half a cycle high, half a cycle low.
- R6: After reset release, the first output rise comes D cycles after the first rising edge of the selected source. D is `cfg_b[5:0]`. The first high phase follows at once.
- R7: `cfg_a[15:13]` selects `phase_clk[n]` as the counting clock. The start-up delay of R6 is therefore measured from that copy's edges.
- R8: `cfg_a[12]`, `cfg_b[15:10]` and `cfg_b[9:8]` have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_clk | input | 8 | Source clock copies; bit n lags bit 0 by n/8 of a period |
| rst | input | 1 | Active-high reset; asynchronous to the counters, also enables word capture |
| cfg_a | input | 16 | Phase select, high time, low time |
| cfg_b | input | 16 | Edge bit, bypass bit, start-up delay |
| clk_out | output | 1 | Divided clock |

## Verification
The hardest behaviour to observe is the start-up delay under a non-zero phase select. Its reference edge is the first rise of a shifted copy after reset release, and no port shows that edge directly. The bench releases reset at a fixed offset from the base clock. From that offset and the selected tap it computes the expected first counting edge, then measures the output's first rise against it in half-cycle units. The frozen-word rule is checked the same way: the bench rewrites both words right after release and confirms that the measured waveform still matches the old settings.

// File: rtl/hl_clk_divider.sv
`timescale 1ns/1ps
module hl_clk_divider #(
  parameter int NPH = 8,
  parameter int FW  = 6
) (
  input  logic [NPH-1:0] phase_clk,
  input  logic           rst,
  input  logic [15:0]    cfg_a,
  input  logic [15:0]    cfg_b,
  output logic           clk_out
);
  localparam int SW = $clog2(NPH);
  localparam int CW = FW + 1;
  localparam logic [CW-1:0] FULL = CW'(1 << FW);
  localparam logic [1:0] S_DLY = 2'd0, S_HI = 2'd1, S_LO = 2'd2;

  logic [SW-1:0] sel_q;
  logic [FW-1:0] hi_f, lo_f, dly_f;
  logic          edge_q, byp_q;

  always_ff @(posedge phase_clk[0]) begin
    if (rst) begin
      sel_q  <= cfg_a[15:13];
      hi_f   <= cfg_a[11:6];
      lo_f   <= cfg_a[5:0];
      edge_q <= cfg_b[7];
      byp_q  <= cfg_b[6];
      dly_f  <= cfg_b[5:0];
    end
  end

  logic [CW-1:0] hi_lim, lo_lim, dly_lim;
  assign hi_lim  = (hi_f == '0) ? FULL : {1'b0, hi_f};
  assign lo_lim  = (lo_f == '0) ? FULL : {1'b0, lo_f};
  assign dly_lim = {1'b0, dly_f};

  logic cnt_clk;
  assign cnt_clk = phase_clk[sel_q];

  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic          lvl, ext;

  always_ff @(posedge cnt_clk or posedge rst) begin
    if (rst) begin
      st  <= S_DLY;
      cnt <= '0;
      lvl <= 1'b0;
    end else begin
      unique case (st)
        S_DLY: if (cnt == dly_lim) begin
                 st <= S_HI; cnt <= CW'(1); lvl <= 1'b1;
               end else cnt <= cnt + 1'b1;
        S_HI:  if (cnt == hi_lim) begin
                 st <= S_LO; cnt <= CW'(1); lvl <= 1'b0;
               end else cnt <= cnt + 1'b1;
        S_LO:  if (cnt == lo_lim) begin
                 st <= S_HI; cnt <= CW'(1); lvl <= 1'b1;
               end else cnt <= cnt + 1'b1;
        default: begin st <= S_DLY; cnt <= '0; lvl <= 1'b0; end
      endcase
    end
  end

  always_ff @(negedge cnt_clk or posedge rst) begin
    if (rst) ext <= 1'b0;
    else     ext <= lvl;
  end

  assign clk_out = byp_q ? (cnt_clk & ~rst) : (lvl | (edge_q & ext));
endmodule

module hl_clk_divider_chk #(parameter int CW = 7) (
  input logic          ref_clk,
  input logic          cnt_clk,
  input logic          rst,
  input logic          clk_out,
  input logic          lvl,
  input logic [1:0]    st,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] hi_lim,
  input logic [CW-1:0] lo_lim,
  input logic [CW-1:0] dly_lim,
  input logic          edge_q,
  input logic          byp_q
);
  a_r1_low_in_reset: assert property (@(posedge ref_clk) rst |-> !clk_out);
  a_r1_cfg_frozen: assert property (@(posedge ref_clk)
    (!rst && !$past(rst)) |-> ($stable(hi_lim) && $stable(lo_lim) && $stable(dly_lim)
                               && $stable(edge_q) && $stable(byp_q)));
  a_r2_high_len: assert property (@(posedge cnt_clk) disable iff (rst)
    $fell(lvl) |-> $past(cnt) == hi_lim);
  a_r2_low_len: assert property (@(posedge cnt_clk) disable iff (rst)
    ($rose(lvl) && $past(st) == 2'd2) |-> $past(cnt) == lo_lim);
  a_r6_delay_len: assert property (@(posedge cnt_clk) disable iff (rst)
    ($rose(lvl) && $past(st) == 2'd0) |-> $past(cnt) == dly_lim);
  a_r3_cnt_bound: assert property (@(posedge cnt_clk) disable iff (rst)
    st != 2'd0 |-> (cnt >= 1 && cnt <= CW'(64)));
endmodule

bind hl_clk_divider hl_clk_divider_chk #(.CW(CW)) u_chk (
  .ref_clk(phase_clk[0]), .cnt_clk(cnt_clk), .rst(rst), .clk_out(clk_out),
  .lvl(lvl), .st(st), .cnt(cnt), .hi_lim(hi_lim), .lo_lim(lo_lim),
  .dly_lim(dly_lim), .edge_q(edge_q), .byp_q(byp_q)
);

// File: tb/test_hl_clk_divider.sv
`timescale 1ns/1ps
module test_hl_clk_divider;
  logic [7:0]  ph;
  logic        rst;
  logic [15:0] cfg_a, cfg_b;
  logic        clk_out;
  int n_chk = 0, n_fail = 0;

  hl_clk_divider i_hl_clk_divider (
    .phase_clk(ph), .rst(rst), .cfg_a(cfg_a), .cfg_b(cfg_b), .clk_out(clk_out)
  );

  // 200 MHz base, eight taps spaced 0.625 ns
  initial begin
    int s;
    s = 0;
    forever begin
      for (int k = 0; k < 8; k++) ph[k] = (((s + 8 - k) % 8) < 4);
      #0.625;
      s = (s + 1) % 8;
    end
  end

  initial begin
    repeat (150000) @(posedge ph[0]);
    n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int halves(input realtime t);
    return int'(t / 2.5);
  endfunction

  task automatic run_cfg(input int h, input int l, input int e, input int d,
                         input int sel, input int nc, input bit junk, input bit poke);
    realtime t0, tf, r1, f2, r2, r3;
    int he, le, exp_hi, exp_per;
    rst   = 1'b1;
    cfg_a = {3'(sel), junk, 6'(h), 6'(l)};
    cfg_b = {junk ? 6'h3F : 6'h00, junk ? 2'b11 : 2'b00, 1'(e), 1'(nc), 6'(d)};
    repeat (4) @(posedge ph[0]);
    #1.3;
    chk(clk_out == 1'b0, "R1 reset low", int'(clk_out), 0);
    t0 = $realtime;
    rst = 1'b0;
    if (poke) begin
      cfg_a = 16'h0041;
      cfg_b = 16'h00C0;
    end
    @(posedge clk_out); r1 = $realtime;
    @(posedge clk_out); r2 = $realtime;
    @(negedge clk_out); f2 = $realtime;
    @(posedge clk_out); r3 = $realtime;
    he = (h == 0) ? 64 : h;
    le = (l == 0) ? 64 : l;
    if (nc != 0) begin
      exp_hi = 1; exp_per = 2;
      chk(halves(f2 - r2 + 0.1) == exp_hi, "R5 bypass high", halves(f2 - r2 + 0.1), exp_hi);
      chk(halves(r3 - r2 + 0.1) == exp_per, "R5 bypass period", halves(r3 - r2 + 0.1), exp_per);
    end else begin
      exp_hi  = 2 * he + e;
      exp_per = 2 * (he + le);
      chk(halves(f2 - r2 + 0.1) == exp_hi, (e != 0) ? "R4 edge high" : "R2 high", halves(f2 - r2 + 0.1), exp_hi);
      chk(halves(r3 - r2 + 0.1) == exp_per, (h == 0 || l == 0) ? "R3 period" : "R2 period", halves(r3 - r2 + 0.1), exp_per);
      tf = ($floor((t0 - sel * 0.625) / 5.0) + 1.0) * 5.0 + sel * 0.625;
      chk(halves(r1 - tf + 0.1) == 2 * d, "R6 R7 delay", halves(r1 - tf + 0.1), 2 * d);
    end
  endtask

  initial begin
    rst = 1'b1; cfg_a = '0; cfg_b = '0;
    // near-exhaustive sweep of small high/low/edge values
    for (int h = 1; h <= 4; h++)
      for (int l = 1; l <= 4; l++)
        for (int e = 0; e < 2; e++)
          run_cfg(h, l, e, 0, 0, 0, 1'b0, 1'b0);
    run_cfg(2, 2, 0, 0, 0, 0, 1'b0, 1'b0);   // R2 divide 4
    run_cfg(1, 2, 1, 0, 0, 0, 1'b0, 1'b0);   // R4 divide 3
    run_cfg(0, 1, 0, 0, 0, 0, 1'b0, 1'b0);   // R3 high 64
    run_cfg(1, 0, 1, 2, 1, 0, 1'b0, 1'b0);   // R3 low 64
    run_cfg(0, 0, 0, 0, 0, 0, 1'b0, 1'b0);   // R3 both 64
    run_cfg(0, 0, 0, 0, 0, 1, 1'b0, 1'b0);   // R5 bypass
    run_cfg(3, 5, 0, 0, 6, 1, 1'b1, 1'b0);   // R5 bypass, R8 junk
    for (int s = 0; s < 8; s++)
      run_cfg(3, 4, s % 2, 5 + s, s, 0, 1'b0, 1'b0);  // R7 every tap, R6
    run_cfg(5, 3, 0, 63, 7, 0, 1'b0, 1'b0);  // R6 max delay
    run_cfg(2, 3, 1, 4, 2, 0, 1'b1, 1'b0);   // R8 reserved bits set
    run_cfg(4, 2, 0, 3, 5, 0, 1'b0, 1'b1);   // R1 words changed after release
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule